// File: doc/BRIEF.md
# Four-Lane Lockstep Vector Core with Slot Broadcast

This block is a small vector processor with four identical lanes that run a single instruction stream in lockstep. Each lane owns a private file of eight 32-bit registers and one 32-bit slot in a shared slot store. The only path between lanes runs through that slot store. A load places one data-memory word into a chosen slot. A pair of copy instructions moves words between every lane's own slot and one of its registers. A broadcast instruction copies one chosen slot into the same register of all four lanes. Multiply and add run in all lanes at once.

Instructions arrive on a valid/ready handshake and each one completes at the clock edge that accepts it. The next instruction therefore always sees the results of the one before. The 256-word data memory can be preloaded through a separate write port. A combinational debug port reads any register of any lane. A typical use is a four-term dot product: both vectors are loaded into the slots and moved into registers, a multiply runs in every lane, the products are stored back to the slots, three broadcasts gather the products into lane 0, and three adds sum them there.

Top module: `simd4_core`

## Requirements
- R1: While `rst` is high at a rising edge, every register of every lane and every slot is cleared to zero. `instr_ready` is low while `rst` is high and high otherwise.
- R2: An instruction word is 20 bits: opcode [19:17], field A [16:14], field B [13:11], field C [10:8], address [7:0]. Opcodes are load=0, toslot-to-register=1, register-to-slot=2, broadcast=3, multiply=4, add=5. A slot number is taken from the low two bits of its field.
- R3: Load (opcode 0) writes data-memory word `address` into the slot given by field A. The other three slots are unchanged.
- R4: Opcode 1 copies each lane's own slot into that lane's register number field A, in all lanes.
- R5: Opcode 2 copies each lane's register number field A into that lane's own slot, in all lanes.
- R6: Broadcast (opcode 3) copies the slot given by field B into register number field A of all four lanes.
- R7: Multiply (opcode 4) sets R[A] = low 32 bits of R[B] * R[C] in every lane.
- R8: Add (opcode 5) sets R[A] = (R[B] + R[C]) mod 2^32 in every lane.
- R9: An instruction is accepted at a rising edge where `instr_valid` and `instr_ready` are both high, and its result is visible right after that edge. Back-to-back instructions see each other's results.
- R10: A word presented while `instr_valid` is low, and opcodes 6 and 7, change no register and no slot.
- R11: `dbg_data` combinationally shows register `dbg_reg` of lane `dbg_lane`.
- R12: When `mem_wr_en` is high at a rising edge, `mem_wr_data` is stored at `mem_wr_addr`, and a later load reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Core can accept an instruction |
| instr_word | input | 20 | Encoded instruction |
| mem_wr_en | input | 1 | Preload write strobe |
| mem_wr_addr | input | 8 | Preload word address |
| mem_wr_data | input | 32 | Preload data |
| dbg_lane | input | 2 | Lane selected for debug read |
| dbg_reg | input | 3 | Register selected for debug read |
| dbg_data | output | 32 | Selected register value |

## Verification
The bench runs a complete four-term dot product. A single wrong slot index, register index or operand order there yields a sum other than the known value 70. Distinct per-lane operands, made different in each lane by loads into separate slots, show whether each lane uses its own slot and not a neighbour's, and whether a broadcast takes the chosen source slot. Multiply and add operands are chosen to overflow 32 bits, which separates truncation from saturation or widening. Idle cycles with a live-looking word, and the two unused opcodes, show that nothing is written when nothing should be.

// File: rtl/simd4_pkg.sv
package simd4_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_SLTOR = 3'd1,
    OP_RTOSL = 3'd2,
    OP_BCAST = 3'd3,
    OP_MUL   = 3'd4,
    OP_ADD   = 3'd5
  } op_e;

  // Per-cycle control, already qualified by the handshake.
  typedef struct packed {
    logic do_load;
    logic do_sltor;
    logic do_rtosl;
    logic do_bcast;
    logic do_alu;
    logic alu_mul;
  } ctrl_t;
endpackage

// File: rtl/simd4_decode.sv
module simd4_decode
  import simd4_pkg::*;
#(
  parameter int RW = 3,
  parameter int AW = 8,
  localparam int IW = 3 + 3 * RW + AW
) (
  input  logic [IW-1:0] word,
  input  logic          fire,
  output ctrl_t         ctl,
  output logic [RW-1:0] f_a,
  output logic [RW-1:0] f_b,
  output logic [RW-1:0] f_c,
  output logic [AW-1:0] addr
);
  logic [2:0] opc;

  assign opc  = word[IW-1 -: 3];
  assign f_a  = word[AW + 3*RW - 1 -: RW];
  assign f_b  = word[AW + 2*RW - 1 -: RW];
  assign f_c  = word[AW + RW - 1 -: RW];
  assign addr = word[AW-1:0];

  always_comb begin
    ctl          = '0;
    ctl.do_load  = fire && (opc == OP_LOAD);
    ctl.do_sltor = fire && (opc == OP_SLTOR);
    ctl.do_rtosl = fire && (opc == OP_RTOSL);
    ctl.do_bcast = fire && (opc == OP_BCAST);
    ctl.do_alu   = fire && ((opc == OP_MUL) || (opc == OP_ADD));
    ctl.alu_mul  = (opc == OP_MUL);
  end
endmodule

// File: rtl/simd4_dmem.sv
module simd4_dmem #(
  parameter int XLEN = 32,
  parameter int AW   = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/simd4_slots.sv
module simd4_slots #(
  parameter int LANES = 4,
  parameter int XLEN  = 32,
  localparam int SW   = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [SW-1:0]   ld_slot,
  input  logic [XLEN-1:0] ld_data,
  input  logic            st_en,
  input  logic [XLEN-1:0] st_data [LANES],
  output logic [XLEN-1:0] slot    [LANES]
);
  for (genvar i = 0; i < LANES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                              slot[i] <= '0;
      else if (st_en)                       slot[i] <= st_data[i];
      else if (ld_en && ld_slot == SW'(i))  slot[i] <= ld_data;
    end

    // A load must leave every slot other than its target alone.
    assert_load_keeps_others_R3 : assert property (@(posedge clk) disable iff (rst)
      (ld_en && !st_en && ld_slot != SW'(i)) |=> $stable(slot[i]));

    // Register-to-slot copy lands the lane's own register value.
    assert_rtosl_copy_R5 : assert property (@(posedge clk) disable iff (rst)
      st_en |=> slot[i] == $past(st_data[i]));
  end
endmodule

// File: rtl/simd4_lane.sv
module simd4_lane
  import simd4_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctl,
  input  logic [RW-1:0]   f_a,
  input  logic [RW-1:0]   f_b,
  input  logic [RW-1:0]   f_c,
  input  logic [XLEN-1:0] own_slot,
  input  logic [XLEN-1:0] bcast,
  output logic [XLEN-1:0] st_val,
  input  logic [RW-1:0]   dbg_idx,
  output logic [XLEN-1:0] dbg_val
);
  function automatic logic [XLEN-1:0] mul_lo(logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    logic [2*XLEN-1:0] full;
    full = {{XLEN{1'b0}}, x} * {{XLEN{1'b0}}, y};
    return full[XLEN-1:0];
  endfunction

  function automatic logic [XLEN-1:0] add_wrap(logic [XLEN-1:0] x, logic [XLEN-1:0] y);
    return x + y;
  endfunction

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] op_b, op_c;
  logic            wr_en;
  logic [RW-1:0]   wr_idx;
  logic [XLEN-1:0] wr_data;

  assign op_b    = regs[f_b];
  assign op_c    = regs[f_c];
  assign st_val  = regs[f_a];
  assign dbg_val = regs[dbg_idx];

  assign wr_en  = ctl.do_sltor || ctl.do_bcast || ctl.do_alu;
  assign wr_idx = f_a;

  always_comb begin
    if (ctl.do_sltor)     wr_data = own_slot;
    else if (ctl.do_bcast) wr_data = bcast;
    else if (ctl.alu_mul) wr_data = mul_lo(op_b, op_c);
    else                  wr_data = add_wrap(op_b, op_c);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                 regs[r] <= '0;
      else if (wr_en && wr_idx == RW'(r))      regs[r] <= wr_data;
    end

    // Registers hold when no write targets them.
    assert_reg_hold_R10 : assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_idx == RW'(r)) |=> $stable(regs[r]));
  end

  // Broadcast value arrives in the target register one edge later.
  assert_bcast_lands_R6 : assert property (@(posedge clk) disable iff (rst)
    ctl.do_bcast |=> regs[$past(f_a)] == $past(bcast));
endmodule

// File: rtl/simd4_core.sv
module simd4_core
  import simd4_pkg::*;
#(
  parameter int LANES = 4,
  parameter int XLEN  = 32,
  parameter int NREG  = 8,
  parameter int AW    = 8,
  localparam int RW   = $clog2(NREG),
  localparam int SW   = $clog2(LANES),
  localparam int IW   = 3 + 3 * RW + AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [IW-1:0]   instr_word,
  input  logic            mem_wr_en,
  input  logic [AW-1:0]   mem_wr_addr,
  input  logic [XLEN-1:0] mem_wr_data,
  input  logic [SW-1:0]   dbg_lane,
  input  logic [RW-1:0]   dbg_reg,
  output logic [XLEN-1:0] dbg_data
);
  ctrl_t           ctl;
  logic            fire;
  logic [RW-1:0]   f_a, f_b, f_c;
  logic [AW-1:0]   addr;
  logic [XLEN-1:0] mem_rdata;
  logic [XLEN-1:0] slot   [LANES];
  logic [XLEN-1:0] st_val [LANES];
  logic [XLEN-1:0] dbg_v  [LANES];
  logic [SW-1:0]   ld_slot, bc_slot;
  logic [XLEN-1:0] bcast;

  assign instr_ready = !rst;
  assign fire        = instr_valid && instr_ready;
  assign ld_slot     = f_a[SW-1:0];
  assign bc_slot     = f_b[SW-1:0];
  assign bcast       = slot[bc_slot];
  assign dbg_data    = dbg_v[dbg_lane];

  simd4_decode #(.RW(RW), .AW(AW)) u_dec (
    .word(instr_word), .fire(fire), .ctl(ctl),
    .f_a(f_a), .f_b(f_b), .f_c(f_c), .addr(addr)
  );

  simd4_dmem #(.XLEN(XLEN), .AW(AW)) u_mem (
    .clk(clk), .we(mem_wr_en), .waddr(mem_wr_addr), .wdata(mem_wr_data),
    .raddr(addr), .rdata(mem_rdata)
  );

  simd4_slots #(.LANES(LANES), .XLEN(XLEN)) u_slots (
    .clk(clk), .rst(rst),
    .ld_en(ctl.do_load), .ld_slot(ld_slot), .ld_data(mem_rdata),
    .st_en(ctl.do_rtosl), .st_data(st_val), .slot(slot)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    simd4_lane #(.XLEN(XLEN), .NREG(NREG)) u_lane (
      .clk(clk), .rst(rst), .ctl(ctl),
      .f_a(f_a), .f_b(f_b), .f_c(f_c),
      .own_slot(slot[l]), .bcast(bcast), .st_val(st_val[l]),
      .dbg_idx(dbg_reg), .dbg_val(dbg_v[l])
    );
  end

  // Loaded word from memory reaches the chosen slot.
  assert_load_lands_R3 : assert property (@(posedge clk) disable iff (rst)
    ctl.do_load |=> slot[$past(ld_slot)] == $past(mem_rdata));

  // Nothing is accepted without a valid word.
  assert_no_fire_idle_R9 : assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !(ctl.do_load || ctl.do_sltor || ctl.do_rtosl || ctl.do_bcast || ctl.do_alu));
endmodule

// File: tb/simd4_core_bench.sv
`timescale 1ns/100ps
module simd4_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [19:0] instr_word = '0;
  logic        mem_wr_en = 1'b0;
  logic [7:0]  mem_wr_addr = '0;
  logic [31:0] mem_wr_data = '0;
  logic [1:0]  dbg_lane = '0;
  logic [2:0]  dbg_reg = '0;
  logic [31:0] dbg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_reg [4][8];
  logic [31:0] m_slot [4];
  logic [31:0] m_mem [256];

  always #2.5 clk = ~clk;

  simd4_core u_simd4_core (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .dbg_lane(dbg_lane), .dbg_reg(dbg_reg), .dbg_data(dbg_data)
  );

  function automatic logic [19:0] enc(int op, int a, int b, int c, int ad);
    return {op[2:0], a[2:0], b[2:0], c[2:0], ad[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(int lane, int r, output logic [31:0] v);
    dbg_lane = lane[1:0];
    dbg_reg  = r[2:0];
    #0.5;
    v = dbg_data;
  endtask

  task automatic compare_all(string req);
    logic [31:0] v;
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 8; r++) begin
        peek(l, r, v);
        check(req, v, m_reg[l][r]);
      end
  endtask

  // Model update written from the requirements (R3..R8, R10).
  task automatic model(logic [19:0] w);
    int op, a, b, c, ad;
    logic [31:0] prod [4];
    op = w[19:17]; a = w[16:14]; b = w[13:11]; c = w[10:8]; ad = w[7:0];
    case (op)
      0: m_slot[a % 4] = m_mem[ad];
      1: for (int l = 0; l < 4; l++) m_reg[l][a] = m_slot[l];
      2: for (int l = 0; l < 4; l++) m_slot[l] = m_reg[l][a];
      3: for (int l = 0; l < 4; l++) m_reg[l][a] = m_slot[b % 4];
      4, 5: begin
        for (int l = 0; l < 4; l++) begin
          longint unsigned x, y;
          x = m_reg[l][b]; y = m_reg[l][c];
          prod[l] = (op == 4) ? 32'(x * y) : 32'(x + y);
        end
        for (int l = 0; l < 4; l++) m_reg[l][a] = prod[l];
      end
      default: ;
    endcase
  endtask

  task automatic issue(logic [19:0] w);
    @(negedge clk);
    instr_word  = w;
    instr_valid = 1'b1;
    @(posedge clk);
    model(w);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic preload(int ad, logic [31:0] d);
    @(negedge clk);
    mem_wr_en = 1'b1; mem_wr_addr = ad[7:0]; mem_wr_data = d;
    @(posedge clk);
    m_mem[ad] = d;
    @(negedge clk);
    mem_wr_en = 1'b0;
  endtask

  // Slots observed through broadcast into R7 of lane 0.
  task automatic check_slots(string req);
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      issue(enc(3, 7, s, 0, 0));
      peek(0, 7, v);
      check(req, v, m_slot[s]);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    @(negedge clk);
    check("R1 ready low in reset", {31'b0, instr_ready}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check("R1 ready high", {31'b0, instr_ready}, 32'd1);
    compare_all("R1 regs cleared");
    for (int s = 0; s < 4; s++) begin
      issue(enc(3, 6, s, 0, 0));
      peek(2, 6, v);
      check("R1 slot cleared", v, 32'd0);
    end
  endtask

  task automatic t_load;
    for (int i = 0; i < 4; i++) preload(20 + i, 32'h1000_0000 * (i + 1) + i);
    issue(enc(0, 5, 0, 0, 22));          // field A=5 -> slot 1 (R2 low bits)
    check_slots("R3 R12 load slot 1 only");
    issue(enc(0, 3, 0, 0, 23));
    issue(enc(0, 0, 0, 0, 20));
    issue(enc(0, 2, 0, 0, 21));
    check_slots("R3 loads to slots");
  endtask

  task automatic t_copy;
    issue(enc(1, 1, 0, 0, 0));
    compare_all("R4 slot to reg");
    issue(enc(5, 2, 1, 1, 0));           // R2 = 2*R1 per lane
    issue(enc(2, 2, 0, 0, 0));
    check_slots("R5 reg to slot");
    issue(enc(3, 4, 2, 0, 0));
    compare_all("R6 broadcast slot 2");
  endtask

  task automatic t_arith;
    preload(30, 32'hFFFF_FFF0); preload(31, 32'h0001_0001);
    preload(32, 32'h8000_0001); preload(33, 32'h7FFF_FFFF);
    for (int i = 0; i < 4; i++) issue(enc(0, i, 0, 0, 30 + i));
    issue(enc(1, 3, 0, 0, 0));
    issue(enc(4, 5, 3, 3, 0));
    compare_all("R7 mul low bits");
    issue(enc(5, 6, 3, 5, 0));
    compare_all("R8 add wraps");
    issue(enc(4, 6, 6, 3, 0));
    issue(enc(5, 6, 6, 6, 0));
    compare_all("R9 back to back");
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr_word = enc(5, 0, 3, 3, 0); instr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    compare_all("R10 valid low ignored");
    issue(enc(6, 1, 2, 3, 30));
    issue(enc(7, 2, 3, 4, 31));
    compare_all("R10 opcodes 6 7 ignored");
    check_slots("R10 slots unchanged");
  endtask

  task automatic t_dot;
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      preload(100 + i, i + 1);
      preload(104 + i, i + 5);
    end
    for (int i = 0; i < 4; i++) issue(enc(0, i, 0, 0, 100 + i));
    issue(enc(1, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) issue(enc(0, i, 0, 0, 104 + i));
    issue(enc(1, 1, 0, 0, 0));
    issue(enc(4, 2, 0, 1, 0));
    issue(enc(2, 2, 0, 0, 0));
    issue(enc(3, 3, 1, 0, 0));
    issue(enc(3, 4, 2, 0, 0));
    issue(enc(3, 5, 3, 0, 0));
    issue(enc(5, 2, 2, 3, 0));
    issue(enc(5, 2, 2, 4, 0));
    issue(enc(5, 2, 2, 5, 0));
    peek(0, 2, v);
    check("R9 dot product sum", v, 32'd70);
    compare_all("R11 debug read all lanes");
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin
      m_slot[l] = '0;
      for (int r = 0; r < 8; r++) m_reg[l][r] = '0;
    end
    for (int a = 0; a < 256; a++) m_mem[a] = 'x;
    repeat (3) @(posedge clk);
    t_reset();
    t_load();
    t_copy();
    t_arith();
    t_idle();
    t_dot();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule